// File: doc/BRIEF.md
# Sticky Alarm Capture with Automatic Far-End Alarms

This block sits beside the receive alarm detectors of a framed trunk interface. Every cycle it samples a vector of level alarm inputs and ORs them into a capture register. A bit in that register, once set, stays set until the host reads the register. A short or sporadic alarm is therefore never missed, even when the host polls slowly. A host-written mask selects which captured bits raise the interrupt line.

In E1 mode the block also produces two request levels for the transmit framer. The first is a remote alarm indication request, raised while basic frame alignment is lost. The second is a multiframe Y-bit request, raised while signaling multiframe alignment is missing. Each request has a control bit that selects its source. At 0 the request follows the sync-loss input. At 1 it follows a bit the host writes. In T1 mode both requests are held low. Inserting these bits into the frame is left to the framer, and detecting the alarms is left to the detectors.

The host port is a plain single-cycle strobe interface: `host_rd` or `host_wr` together with a 2-bit address. Read data is combinational from the address and takes no wait states. No data stream passes through the block, so no valid/ready handshake is used.

Top module: `sab_top`

## Requirements
- R1: After reset the capture register, the mask and the control register are all 0, `irq` is 0, and in E1 mode both requests follow their sync-loss inputs.
- R2: An alarm input bit that is high at a clock edge sets its capture bit from the next cycle on.
- R3: A set capture bit stays set until a read of address 0. Reads of other addresses and idle cycles leave it set.
- R4: A read of address 0 loads the capture register with that cycle's alarm inputs. Bits whose alarm is low are cleared, and bits whose alarm is still high stay set.
- R5: During any cycle with `host_addr`=0, `host_rdata` shows the capture register as it stood before that cycle's edge.
- R6: `irq` is high exactly when some capture bit is set and its mask bit is 1. It falls after a read of address 0 that leaves no masked bit set.
- R7: Address 1 is the read/write mask, one bit per alarm. Address 2 is the control register, read/write in bits 3:0 and reading 0 above them: bit 0 selects manual RAI, bit 1 selects manual Y, bit 2 is the manual RAI value, bit 3 is the manual Y value. Address 3 reads 0.
- R8: In E1 mode (`e1_mode`=1) with control bit 0 at 0, `rai_req` equals `frame_sync_lost`.
- R9: In E1 mode with control bit 1 at 0, `y_req` equals `mf_sync_lost`.
- R10: In E1 mode, a control bit 0 (or bit 1) set to 1 makes `rai_req` (or `y_req`) equal control bit 2 (or bit 3), regardless of the sync-loss input.
- R11: With `e1_mode`=0, `rai_req` and `y_req` are 0.
- R12: A write to address 0 has no effect on the capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alarm_in | input | N_ALARM | Level alarm inputs |
| e1_mode | input | 1 | 1 = E1, 0 = T1 |
| frame_sync_lost | input | 1 | Basic frame alignment lost |
| mf_sync_lost | input | 1 | Signaling multiframe alignment missing |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | N_ALARM | Write data |
| host_rdata | output | N_ALARM | Read data |
| irq | output | 1 | Masked interrupt |
| rai_req | output | 1 | Remote alarm indication request |
| y_req | output | 1 | Multiframe Y-bit request |

## Verification
The delicate overlap is a new alarm arriving in the same cycle as a clear-on-read of the capture register. Mask writes landing in the same cycle as a capture can also collide. The bench provokes both deliberately in directed steps, and they also recur often in the random phase. Read strobes and sparse alarm bits are drawn independently each cycle. A cycle model computes the capture value as "alarms of the read cycle" on a clear and "old OR alarms" otherwise, and it judges `host_rdata`, `irq` and both requests every cycle against that model.

// File: rtl/sab_pkg.sv
package sab_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CAPT = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
  localparam int CTRL_W = 4;

  typedef struct packed {
    logic man_y;       // bit 3
    logic man_rai;     // bit 2
    logic y_manual;    // bit 1
    logic rai_manual;  // bit 0
  } ctrl_t;
endpackage

// File: rtl/sab_capture.sv
module sab_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] alarm_in,
  input  logic         clear,
  output logic [N-1:0] capt_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)        capt_q[i] <= 1'b0;
      else if (clear) capt_q[i] <= alarm_in[i];
      else            capt_q[i] <= capt_q[i] | alarm_in[i];
    end
  end
endmodule

// File: rtl/sab_regs.sv
module sab_regs
  import sab_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      mask_q,
  output ctrl_t             ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      ctrl_q <= '0;
    end else if (wr) begin
      if (addr == A_MASK) mask_q <= wdata;
      if (addr == A_CTRL) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end
endmodule

// File: rtl/sab_farend.sv
module sab_farend
  import sab_pkg::*;
(
  input  logic  e1_mode,
  input  logic  frame_sync_lost,
  input  logic  mf_sync_lost,
  input  ctrl_t ctrl,
  output logic  rai_req,
  output logic  y_req
);
  logic rai_src, y_src;
  always_comb begin
    rai_src = ctrl.rai_manual ? ctrl.man_rai : frame_sync_lost;
    y_src   = ctrl.y_manual   ? ctrl.man_y   : mf_sync_lost;
    rai_req = e1_mode & rai_src;
    y_req   = e1_mode & y_src;
  end
endmodule

// File: rtl/sab_top.sv
module sab_top
  import sab_pkg::*;
#(
  parameter int N_ALARM = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_ALARM-1:0] alarm_in,
  input  logic               e1_mode,
  input  logic               frame_sync_lost,
  input  logic               mf_sync_lost,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [1:0]         host_addr,
  input  logic [N_ALARM-1:0] host_wdata,
  output logic [N_ALARM-1:0] host_rdata,
  output logic               irq,
  output logic               rai_req,
  output logic               y_req
);
  localparam int PAD_W = N_ALARM - CTRL_W;

  logic [N_ALARM-1:0] capt_q;
  logic [N_ALARM-1:0] mask_q;
  ctrl_t              ctrl_q;
  logic               capt_clear;

  assign capt_clear = host_rd && (host_addr == A_CAPT);

  sab_capture #(.N(N_ALARM)) u_capt (
    .clk(clk), .rst(rst), .alarm_in(alarm_in),
    .clear(capt_clear), .capt_q(capt_q)
  );

  sab_regs #(.N(N_ALARM)) u_regs (
    .clk(clk), .rst(rst), .wr(host_wr), .addr(host_addr),
    .wdata(host_wdata), .mask_q(mask_q), .ctrl_q(ctrl_q)
  );

  sab_farend u_far (
    .e1_mode(e1_mode), .frame_sync_lost(frame_sync_lost),
    .mf_sync_lost(mf_sync_lost), .ctrl(ctrl_q),
    .rai_req(rai_req), .y_req(y_req)
  );

  always_comb begin
    case (host_addr)
      A_CAPT:  host_rdata = capt_q;
      A_MASK:  host_rdata = mask_q;
      A_CTRL:  host_rdata = {{PAD_W{1'b0}}, ctrl_q};
      default: host_rdata = '0;
    endcase
  end

  assign irq = |(capt_q & mask_q);
endmodule

// File: rtl/sab_checker.sv
module sab_checker
  import sab_pkg::*;
#(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] alarm_in,
  input logic         e1_mode,
  input logic         frame_sync_lost,
  input logic         mf_sync_lost,
  input logic         host_rd,
  input logic         host_wr,
  input logic [1:0]   host_addr,
  input logic         irq,
  input logic         rai_req,
  input logic         y_req,
  input logic [N-1:0] capt_q,
  input ctrl_t        ctrl_q
);
  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (|alarm_in) |=> ((capt_q & $past(alarm_in)) == $past(alarm_in)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(host_rd && host_addr == A_CAPT) |=> ((capt_q & $past(capt_q)) == $past(capt_q)));

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == A_CAPT) |=> (capt_q == $past(alarm_in)));

  p_irq_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == A_CAPT && alarm_in == '0) |=> !irq);

  p_auto_rai_r8: assert property (@(posedge clk) disable iff (rst)
    (e1_mode && !ctrl_q.rai_manual && frame_sync_lost) |-> rai_req);

  p_auto_y_r9: assert property (@(posedge clk) disable iff (rst)
    (e1_mode && !ctrl_q.y_manual && mf_sync_lost) |-> y_req);

  p_t1_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !e1_mode |-> (!rai_req && !y_req));

  p_capt_wr_r12: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_rd && host_addr == A_CAPT && alarm_in == '0) |=> (capt_q == $past(capt_q)));
endmodule

bind sab_top sab_checker #(.N(N_ALARM)) u_chk (
  .clk(clk), .rst(rst), .alarm_in(alarm_in), .e1_mode(e1_mode),
  .frame_sync_lost(frame_sync_lost), .mf_sync_lost(mf_sync_lost),
  .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
  .irq(irq), .rai_req(rai_req), .y_req(y_req),
  .capt_q(capt_q), .ctrl_q(ctrl_q)
);

// File: tb/sab_top_bench.sv
module sab_top_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] alarm_in;
  logic         e1_mode, frame_sync_lost, mf_sync_lost;
  logic         host_rd, host_wr;
  logic [1:0]   host_addr;
  logic [N-1:0] host_wdata;
  logic [N-1:0] host_rdata;
  logic         irq, rai_req, y_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [N-1:0] m_capt, m_mask;
  logic [3:0]   m_ctrl;

  always #5 clk = ~clk;

  sab_top #(.N_ALARM(N)) u_sab_top (
    .clk(clk), .rst(rst), .alarm_in(alarm_in), .e1_mode(e1_mode),
    .frame_sync_lost(frame_sync_lost), .mf_sync_lost(mf_sync_lost),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .rai_req(rai_req), .y_req(y_req)
  );

  function automatic logic [N-1:0] f_rdata(logic [1:0] a);
    case (a)
      2'd0: return m_capt;
      2'd1: return m_mask;
      2'd2: return {{(N-4){1'b0}}, m_ctrl};
      default: return '0;
    endcase
  endfunction

  function automatic logic f_rai();
    if (!e1_mode) return 1'b0;
    return m_ctrl[0] ? m_ctrl[2] : frame_sync_lost;
  endfunction

  function automatic logic f_y();
    if (!e1_mode) return 1'b0;
    return m_ctrl[1] ? m_ctrl[3] : mf_sync_lost;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, check outputs, then advance model across the posedge.
  task automatic step(logic [N-1:0] al, logic rd, logic wr, logic [1:0] a,
                      logic [N-1:0] wd, logic e1, logic fl, logic ml);
    @(negedge clk);
    alarm_in = al; host_rd = rd; host_wr = wr; host_addr = a; host_wdata = wd;
    e1_mode = e1; frame_sync_lost = fl; mf_sync_lost = ml;
    #1;
    check((a == 2'd0) ? "R5 rdata" : "R7 rdata", host_rdata, f_rdata(a));
    check("R6 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_capt & m_mask)});
    check(!e1 ? "R11 rai" : (m_ctrl[0] ? "R10 rai" : "R8 rai"),
          {{(N-1){1'b0}}, rai_req}, {{(N-1){1'b0}}, f_rai()});
    check(!e1 ? "R11 y" : (m_ctrl[1] ? "R10 y" : "R9 y"),
          {{(N-1){1'b0}}, y_req}, {{(N-1){1'b0}}, f_y()});
    @(posedge clk);
    if (rd && a == 2'd0) m_capt = al; else m_capt = m_capt | al;
    if (wr && a == 2'd1) m_mask = wd;
    if (wr && a == 2'd2) m_ctrl = wd[3:0];
  endtask

  task automatic peek(string tag, logic [N-1:0] exp);
    @(negedge clk);
    alarm_in = '0; host_rd = 1'b0; host_wr = 1'b0; host_addr = 2'd0;
    #1;
    check(tag, host_rdata, exp);
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; alarm_in = '0; host_rd = 0; host_wr = 0; host_addr = 0;
    host_wdata = '0; e1_mode = 1; frame_sync_lost = 1; mf_sync_lost = 0;
    m_capt = '0; m_mask = '0; m_ctrl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state
    check("R1 capt", host_rdata, '0);
    check("R1 irq", {{(N-1){1'b0}}, irq}, '0);
    check("R1 rai", {{(N-1){1'b0}}, rai_req}, {{(N-1){1'b0}}, 1'b1});
    check("R1 y", {{(N-1){1'b0}}, y_req}, '0);

    // R2: one-cycle pulse captured
    step(8'h04, 0, 0, 2'd1, '0, 1, 0, 0);
    peek("R2 set", 8'h04);
    // R3: held over idle and over reads of other addresses
    step('0, 1, 0, 2'd1, '0, 1, 0, 0);
    step('0, 1, 0, 2'd2, '0, 1, 0, 0);
    peek("R3 hold", 8'h04);
    // R12: write to capture address ignored
    step('0, 0, 1, 2'd0, 8'hFF, 1, 0, 0);
    peek("R12 wr ignored", 8'h04);
    // R6 + mask write in the same cycle as a new capture
    step(8'h10, 0, 1, 2'd1, 8'h14, 1, 0, 0);
    peek("R2 set2", 8'h14);
    // R4: clear while one alarm is still active
    step(8'h10, 1, 0, 2'd0, '0, 1, 0, 0);
    peek("R4 clear keeps live", 8'h10);
    step('0, 1, 0, 2'd0, '0, 1, 0, 0);
    peek("R4 clear all", 8'h00);
    // R10: manual selection overrides sync inputs
    step('0, 0, 1, 2'd2, 8'h07, 1, 0, 1);
    step('0, 0, 0, 2'd2, '0, 1, 0, 1);
    // R11: T1 mode silences requests
    step('0, 0, 0, 2'd2, '0, 0, 1, 1);
    step('0, 0, 1, 2'd2, 8'h00, 1, 1, 1);
    step('0, 0, 0, 2'd2, '0, 1, 1, 0);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] al;
      al = '0;
      for (int b = 0; b < N; b++) al[b] = (($urandom % 8) == 0);
      step(al, ($urandom % 4) == 0, ($urandom % 6) == 0, 2'($urandom % 4),
           N'($urandom), ($urandom % 5) != 0, $urandom % 2, $urandom % 2);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule